// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a running calendar and raises an alarm when the time reaches a programmed point. Five alarm registers hold a target second, minute, hour, day of the month and day of the week, each in BCD. Each register also carries a disable bit. A field whose disable bit is set takes no part in the comparison, so software can build alarms such as "every hour at minute 15" or "each Saturday at 23:00".

The live calendar fields come from a separate time counter, together with a one-cycle strobe that marks each new second. The match is evaluated only on that strobe. When every enabled field equals its live counterpart, a sticky alarm flag is set. The flag stays set until software writes a zero to it. A separate enable bit lets the flag pull the active-low interrupt output low. Software reaches the alarm registers and the flag and enable bits through a simple byte-wide register port.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, the flag (bit 4 of address 0x01) and the interrupt enable (bit 1 of address 0x01) are 0 and `irq_n` is 1. Every alarm register reads 0x80, which means its field is disabled.
- R2: The alarm registers sit at addresses 0x0A to 0x0E, in the order second, minute, hour, day of month, weekday. A read returns the disable bit in bit 7 and the value bits kept for that field: 7 bits for second and minute, 6 bits for hour and day, and 3 bits for weekday. Other value bits read 0. Unmapped addresses read 0x00, and at address 0x01 only bits 4 and 1 read non-zero.
- R3: The flag is set one clock after a tick cycle in which every enabled field equals its live value.
- R4: A field whose alarm register has bit 7 set is ignored in the comparison.
- R5: When all five fields are disabled, the flag is never set.
- R6: Without a tick, a matching calendar does not set the flag.
- R7: The flag stays set after the live time stops matching, including across later ticks.
- R8: Writing address 0x01 with bit 4 equal to 0 clears the flag. Writing it with bit 4 equal to 1 leaves the flag unchanged. If a clearing write and a setting match happen in the same cycle, the flag ends up set.
- R9: `irq_n` is 0 exactly when both the flag and the interrupt enable are 1.
- R10: A mismatch in any single enabled field prevents the flag from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe at each new second |
| live_sec | input | 7 | Live seconds, BCD |
| live_min | input | 7 | Live minutes, BCD |
| live_hour | input | 6 | Live hours, BCD |
| live_mday | input | 6 | Live day of month, BCD |
| live_wday | input | 3 | Live weekday |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions assume that `tick` lasts a single cycle. They also assume that the live fields are stable during the tick cycle and that register writes are single-cycle strobes sampled at the clock edge. The bench drives every input on the falling clock edge and raises `tick` for exactly one cycle with the live fields already settled. In one deliberate case it holds a clearing write on the same edge as a matching tick, to exercise the priority rule. No other input changes near the sampling edge.

// File: rtl/cal_alarm_pkg.sv
// Package: shared constants for the calendar alarm comparator.
// Assumes byte-wide registers and a 5-bit register address space.
package cal_alarm_pkg;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int NUM_FIELDS = 5;
    localparam int LIVE_W     = 7;
    localparam int DIS_BIT    = 7;
    localparam int AF_BIT     = 4;
    localparam int AIE_BIT    = 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'h01;
    localparam logic [ADDR_W-1:0] ALM_BASE  = 5'h0A;

    // Number of value bits kept for field idx (sec, min, hour, mday, wday)
    function automatic int fld_w(input int idx);
        case (idx)
            0, 1:    return 7;
            2, 3:    return 6;
            default: return 3;
        endcase
    endfunction

    // Mask of kept value bits for field idx
    function automatic logic [LIVE_W-1:0] fld_mask(input int idx);
        return LIVE_W'((1 << fld_w(idx)) - 1);
    endfunction
endpackage

// File: rtl/alarm_regfile.sv
// Module: alarm_regfile
// Holds the alarm target registers. It stores the disable bit and only the
// value bits that each field keeps.
// Assumes: writes are single-cycle strobes; reset is synchronous, active low.
module alarm_regfile
    import cal_alarm_pkg::*;
#(
    parameter int N = NUM_FIELDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [N-1:0][DATA_W-1:0]   alm_q
);
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(1 << DIS_BIT);

    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALM_BASE + i);
        localparam logic [LIVE_W-1:0] MASK    = fld_mask(i);

        // Load this field's register on a write to its address
        always_ff @(posedge clk) begin
            if (!rst_n)
                alm_q[i] <= RST_VAL;
            else if (we && addr == MY_ADDR)
                alm_q[i] <= {wdata[DIS_BIT], wdata[LIVE_W-1:0] & MASK};
        end
    end
endmodule

// File: rtl/alarm_field_cmp.sv
// Module: alarm_field_cmp
// Compares each alarm field against its live value. A field with the disable
// bit set is skipped. Reports a match only if at least one field is enabled.
// Assumes: live values are stable while they are compared.
module alarm_field_cmp
    import cal_alarm_pkg::*;
#(
    parameter int N = NUM_FIELDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0][DATA_W-1:0]   alm_q,
    input  logic [N-1:0][LIVE_W-1:0]   live,
    output logic                       match_all
);
    logic [N-1:0] en;
    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam logic [LIVE_W-1:0] MASK = fld_mask(i);

        // Per-field enable and equality on the kept value bits
        always_comb begin
            en[i] = !alm_q[i][DIS_BIT];
            eq[i] = (alm_q[i][LIVE_W-1:0] & MASK) == (live[i] & MASK);
        end
    end

    // Combine: every enabled field equal, and at least one field enabled
    always_comb match_all = (|en) && (&(eq | ~en));

    AST_NONE_ENABLED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !match_all); // R5
    AST_DISABLED_FIELD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_all && alm_q[0][DIS_BIT]) |-> ($countones(en) >= 1)); // R4
endmodule

// File: rtl/alarm_flag_ctrl.sv
// Module: alarm_flag_ctrl
// Keeps the sticky alarm flag and the interrupt enable. A match on a tick sets
// the flag. A control write with a zero flag bit clears it, and a set wins
// over a clear in the same cycle.
// Assumes: tick is a one-cycle strobe.
module alarm_flag_ctrl
    import cal_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match_all,
    input  logic ctrl_we,
    input  logic wr_af,
    input  logic wr_aie,
    output logic af_q,
    output logic aie_q
);
    logic set_ev;
    logic clr_ev;

    // Decode the set and clear events
    always_comb begin
        set_ev = tick && match_all;
        clr_ev = ctrl_we && !wr_af;
    end

    // Sticky flag register; setting takes priority over clearing
    always_ff @(posedge clk) begin
        if (!rst_n)      af_q <= 1'b0;
        else if (set_ev) af_q <= 1'b1;
        else if (clr_ev) af_q <= 1'b0;
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)       aie_q <= 1'b0;
        else if (ctrl_we) aie_q <= wr_aie;
    end

    AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af_q) |-> $past(tick)); // R6
    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match_all) |=> af_q); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (af_q && !(ctrl_we && !wr_af)) |=> af_q); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wr_af && !(tick && match_all)) |=> !af_q); // R8
endmodule

// File: rtl/cal_alarm_match.sv
// Module: cal_alarm_match (top)
// Calendar alarm with per-field disable, a sticky flag and a gated active-low
// interrupt. Register reads are combinational from reg_addr.
// Assumes: live fields are BCD and stable during a tick cycle.
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [6:0]        live_sec,
    input  logic [6:0]        live_min,
    input  logic [5:0]        live_hour,
    input  logic [5:0]        live_mday,
    input  logic [2:0]        live_wday,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_n
);
    logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_q;
    logic [NUM_FIELDS-1:0][LIVE_W-1:0] live;
    logic match_all;
    logic af_q;
    logic aie_q;
    logic ctrl_we;

    // Gather the live fields in register order, zero-extended
    always_comb begin
        live[0] = live_sec;
        live[1] = live_min;
        live[2] = LIVE_W'(live_hour);
        live[3] = LIVE_W'(live_mday);
        live[4] = LIVE_W'(live_wday);
        ctrl_we = reg_we && reg_addr == CTRL_ADDR;
    end

    alarm_regfile #(.N(NUM_FIELDS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .alm_q (alm_q)
    );

    alarm_field_cmp #(.N(NUM_FIELDS)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .alm_q     (alm_q),
        .live      (live),
        .match_all (match_all)
    );

    alarm_flag_ctrl u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .match_all (match_all),
        .ctrl_we   (ctrl_we),
        .wr_af     (reg_wdata[AF_BIT]),
        .wr_aie    (reg_wdata[AIE_BIT]),
        .af_q      (af_q),
        .aie_q     (aie_q)
    );

    // Read multiplexer: control byte, alarm registers, zero elsewhere
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata[AF_BIT]  = af_q;
            reg_rdata[AIE_BIT] = aie_q;
        end
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (reg_addr == ADDR_W'(ALM_BASE + i))
                reg_rdata = alm_q[i];
        end
    end

    // Interrupt output: low while the flag is set and enabled
    always_comb irq_n = !(af_q && aie_q);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (af_q && aie_q)); // R9
    AST_IRQ_HELD_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (af_q && aie_q) |-> !irq_n); // R9
endmodule

// File: tb/cal_alarm_match_bench.sv
`timescale 1ns/1ps
module cal_alarm_match_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [6:0] live_sec = '0;
    logic [6:0] live_min = '0;
    logic [5:0] live_hour = '0;
    logic [5:0] live_mday = '0;
    logic [2:0] live_wday = '0;
    logic reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cal_alarm_match u_cal_alarm_match (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour),
        .live_mday(live_mday), .live_wday(live_wday),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    // {a_sec,a_min,a_hr,a_md,a_wd, l_sec,l_min,l_hr,l_md,l_wd, tick, exp}
    localparam int NV = 8;
    localparam logic [70:0] VEC [NV] = '{
        {8'h30,8'h15,8'h12,8'h25,8'h03, 7'h30,7'h15,6'h12,6'h25,3'd3, 1'b1,1'b1}, // R3
        {8'h30,8'h15,8'h12,8'h25,8'h03, 7'h30,7'h16,6'h12,6'h25,3'd3, 1'b1,1'b0}, // R10
        {8'h30,8'h95,8'h12,8'h25,8'h03, 7'h30,7'h16,6'h12,6'h25,3'd3, 1'b1,1'b1}, // R4
        {8'h80,8'h80,8'h80,8'h80,8'h80, 7'h00,7'h00,6'h00,6'h00,3'd0, 1'b1,1'b0}, // R5
        {8'h59,8'h80,8'h80,8'h80,8'h80, 7'h59,7'h42,6'h07,6'h11,3'd1, 1'b1,1'b1}, // R4
        {8'h30,8'h15,8'h12,8'h25,8'h03, 7'h30,7'h15,6'h12,6'h25,3'd3, 1'b0,1'b0}, // R6
        {8'h80,8'h80,8'h80,8'h80,8'h06, 7'h10,7'h10,6'h10,6'h10,3'd5, 1'b1,1'b0}, // R10
        {8'h80,8'h80,8'h23,8'h31,8'h80, 7'h05,7'h44,6'h23,6'h31,3'd2, 1'b1,1'b1}  // R4
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic set_live(input logic [6:0] s, input logic [6:0] m,
                            input logic [5:0] h, input logic [5:0] md, input logic [2:0] wd);
        live_sec = s; live_min = m; live_hour = h; live_mday = md; live_wday = wd;
    endtask

    task automatic pulse(input logic t);
        @(negedge clk);
        tick = t;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h01, d); check("R1 ctrl", d, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        for (int i = 0; i < 5; i++) begin
            rd(5'(5'h0A + i), d); check("R1 alarm reg", d, 8'h80);
        end

        // R2: readback masking and unmapped addresses
        wr(5'h0A, 8'hFF); rd(5'h0A, d); check("R2 sec mask", d, 8'hFF);
        wr(5'h0C, 8'hFF); rd(5'h0C, d); check("R2 hour mask", d, 8'hBF);
        wr(5'h0E, 8'hFF); rd(5'h0E, d); check("R2 wday mask", d, 8'h87);
        wr(5'h0B, 8'h7F); rd(5'h0B, d); check("R2 min mask", d, 8'h7F);
        rd(5'h05, d); check("R2 unmapped", d, 8'h00);
        wr(5'h01, 8'hED); rd(5'h01, d); check("R2 ctrl bits", d, 8'h00);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [70:0] e;
            e = VEC[v];
            wr(5'h0A, e[70:63]); wr(5'h0B, e[62:55]); wr(5'h0C, e[54:47]);
            wr(5'h0D, e[46:39]); wr(5'h0E, e[38:31]);
            wr(5'h01, 8'h00);
            set_live(e[30:24], e[23:17], e[16:11], e[10:5], e[4:2]);
            pulse(e[1]);
            rd(5'h01, d);
            check($sformatf("R3/R4/R5/R6/R10 vector %0d", v), {3'd0, d[4], 4'd0}, {3'd0, e[0], 4'd0});
        end

        // R7: flag sticky after mismatch and a later tick
        wr(5'h0A, 8'h30); wr(5'h0B, 8'h15); wr(5'h0C, 8'h12); wr(5'h0D, 8'h25); wr(5'h0E, 8'h03);
        wr(5'h01, 8'h00);
        set_live(7'h30, 7'h15, 6'h12, 6'h25, 3'd3);
        pulse(1'b1);
        set_live(7'h31, 7'h15, 6'h12, 6'h25, 3'd3);
        pulse(1'b1);
        repeat (4) @(negedge clk);
        rd(5'h01, d); check("R7 sticky", d, 8'h10);

        // R9: interrupt gating
        check("R9 irq off while disabled", {7'd0, irq_n}, 8'h01);
        wr(5'h01, 8'h12);
        rd(5'h01, d); check("R8 write one keeps flag", d, 8'h12);
        check("R9 irq asserted", {7'd0, irq_n}, 8'h00);
        wr(5'h01, 8'h02);
        check("R9 irq released after clear", {7'd0, irq_n}, 8'h01);

        // R6 and R8: no re-set without tick; writing one does not set
        set_live(7'h30, 7'h15, 6'h12, 6'h25, 3'd3);
        repeat (5) @(negedge clk);
        wr(5'h01, 8'h12);
        rd(5'h01, d); check("R6 R8 no set without tick", d, 8'h02);

        // R8: set wins over a clearing write in the same cycle
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 5'h01; reg_wdata = 8'h00;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0;
        rd(5'h01, d); check("R8 set wins", d, 8'h10);

        // R1: reset returns everything to defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(5'h01, d); check("R1 ctrl after reset", d, 8'h00);
        rd(5'h0C, d); check("R1 alarm after reset", d, 8'h80);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule